// File: doc/BRIEF.md
# Periodic Tick Timer

The block is a free-running down-counter that produces a steady time base for an operating system or a scheduler. Software programs a reload value, picks whether the counter advances on every core clock or once every eight core clocks, and starts it. Each time the count passes from one to zero, a sticky flag is set. If the interrupt enable is on, the tick interrupt line then rises. Reading the control register returns the flag and clears it.

The divide-by-eight option is not a second clock. A prescaler sends a one-cycle enable pulse once every eight core cycles, so the whole block stays in one clock domain. Rewriting the reload value does not disturb the count in progress; the new value is used at the next reload. Writing the current-value register forces the count to zero.

Top module: `tick_timer`

## Requirements
- R1: The reload register holds 24 bits. Write data bits 31..24 are dropped, so reading it back after writing 0xFFFFFFFF gives 0x00FFFFFF.
- R2: Control bit 2 selects the counting rate. When the bit is 1, the counter steps on every core clock. When it is 0, the counter steps once every 8 core clocks.
- R3: While running with a reload value R of 1 or more, consecutive flag events are exactly R+1 counting steps apart. That is R+1 core cycles in fast mode and 8*(R+1) core cycles in slow mode.
- R4: While control bit 0 (run) is 0, the count holds its value.
- R5: Writing any data to the current-value register sets the count to 0. The next counting step then loads the reload value and does not set the flag.
- R6: The flag is set on the counting step that takes the count from 1 to 0. It reads back in control bit 16, and a read of the control register clears it. If a set and a clear fall in the same cycle, the set wins.
- R7: tick_irq is high exactly when, one cycle earlier, the flag was set and control bit 1 (interrupt enable) was 1.
- R8: With a reload value of 0, a count at zero stays at zero and no flag is raised, even while running.
- R9: A write to the reload register leaves the count in progress untouched, and the value written is loaded at the next reload.
- R10: Register map by bus_addr:
  - 0 is control/status: bit 0 run, bit 1 interrupt enable, bit 2 source, bit 16 flag.
  - 1 is reload.
  - 2 is current value.
  - 3 reads as zero.

  Read data appears on bus_rdata in the cycle after the read request. Every register is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after a read |
| tick_irq | output | 1 | Tick interrupt, level until the flag is read |

## Verification
A count that decrements wrongly or reloads at the wrong moment shows directly in the time between tick_irq rising edges. Each such edge is compared against R+1 or 8*(R+1) cycles, so the error appears within one period. A corrupted reload or a missed clear of the current value shifts the very next tick by a known number of cycles. A flag that fails to set, or is never cleared, shows in control bit 16 on the next read and on tick_irq one cycle after the flag changes.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL    = 2'd0,
    REG_RELOAD  = 2'd1,
    REG_CURRENT = 2'd2,
    REG_SPARE   = 2'd3
  } reg_addr_e;

  // bit positions inside the control/status word
  localparam int unsigned BIT_RUN   = 0;
  localparam int unsigned BIT_IRQEN = 1;
  localparam int unsigned BIT_SRC   = 2;
  localparam int unsigned BIT_FLAG  = 16;

  typedef struct packed {
    logic src_core;
    logic irq_en;
    logic run;
  } ctrl_t;

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int unsigned DIV = 8
) (
  input  logic clk,
  input  logic rst,
  output logic pulse_o
);

  generate
    if (DIV <= 1) begin : g_bypass
      assign pulse_o = 1'b1;
    end else begin : g_count
      localparam int unsigned PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);

      logic [PW-1:0] phase_q;
      logic          pulse_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          phase_q <= '0;
          pulse_q <= 1'b0;
        end else if (phase_q == LAST) begin
          phase_q <= '0;
          pulse_q <= 1'b1;
        end else begin
          phase_q <= phase_q + 1'b1;
          pulse_q <= 1'b0;
        end
      end

      assign pulse_o = pulse_q;
    end
  endgenerate

endmodule

// File: rtl/tick_downcounter.sv
module tick_downcounter #(
  parameter int unsigned CW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_i,
  input  logic          clear_i,
  input  logic [CW-1:0] reload_i,
  input  logic          flag_clr_i,
  output logic [CW-1:0] count_o,
  output logic          flag_o
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] count_q;
  logic          flag_q;
  logic          zero_hit;

  // count leaves 1 and lands on 0 on this step
  assign zero_hit = step_i && !clear_i && (count_q == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (clear_i) begin
      count_q <= '0;
    end else if (step_i) begin
      if (count_q == '0) begin
        count_q <= reload_i;
      end else begin
        count_q <= count_q - ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else if (zero_hit) begin
      flag_q <= 1'b1;
    end else if (flag_clr_i) begin
      flag_q <= 1'b0;
    end
  end

  assign count_o = count_q;
  assign flag_o  = flag_q;

endmodule

// File: rtl/tick_regbank.sv
module tick_regbank
  import tick_timer_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic [CW-1:0]     count_i,
  input  logic              flag_i,
  output logic [DW-1:0]     bus_rdata,
  output ctrl_t             ctrl_o,
  output logic [CW-1:0]     reload_o,
  output logic              clear_cur_o,
  output logic              rd_ctrl_o
);

  reg_addr_e     sel;
  logic          wr_req;
  logic          rd_req;
  ctrl_t         ctrl_q;
  logic [CW-1:0] reload_q;
  logic [DW-1:0] rd_mux;
  logic [DW-1:0] rdata_q;

  assign sel    = reg_addr_e'(bus_addr);
  assign wr_req = bus_en && bus_we;
  assign rd_req = bus_en && !bus_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else if (wr_req) begin
      if (sel == REG_CTRL) begin
        ctrl_q.run      <= bus_wdata[BIT_RUN];
        ctrl_q.irq_en   <= bus_wdata[BIT_IRQEN];
        ctrl_q.src_core <= bus_wdata[BIT_SRC];
      end
      if (sel == REG_RELOAD) begin
        reload_q <= bus_wdata[CW-1:0];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      REG_CTRL: begin
        rd_mux[BIT_RUN]   = ctrl_q.run;
        rd_mux[BIT_IRQEN] = ctrl_q.irq_en;
        rd_mux[BIT_SRC]   = ctrl_q.src_core;
        rd_mux[BIT_FLAG]  = flag_i;
      end
      REG_RELOAD:  rd_mux = DW'(reload_q);
      REG_CURRENT: rd_mux = DW'(count_i);
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_req) begin
      rdata_q <= rd_mux;
    end
  end

  assign bus_rdata   = rdata_q;
  assign ctrl_o      = ctrl_q;
  assign reload_o    = reload_q;
  assign clear_cur_o = wr_req && (sel == REG_CURRENT);
  assign rd_ctrl_o   = rd_req && (sel == REG_CTRL);

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned CW  = 24,
  parameter int unsigned DW  = 32,
  parameter int unsigned DIV = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              tick_irq
);

  ctrl_t         ctrl;
  logic          run_en;
  logic          irq_en;
  logic          div_pulse;
  logic          step;
  logic          clr_cur;
  logic          rd_ctrl;
  logic [CW-1:0] reload_val;
  logic [CW-1:0] cnt_val;
  logic          cnt_flag;

  tick_prescaler #(.DIV(DIV)) u_presc (
    .clk     (clk),
    .rst     (rst),
    .pulse_o (div_pulse)
  );

  tick_regbank #(.DW(DW), .CW(CW)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .bus_en      (bus_en),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .count_i     (cnt_val),
    .flag_i      (cnt_flag),
    .bus_rdata   (bus_rdata),
    .ctrl_o      (ctrl),
    .reload_o    (reload_val),
    .clear_cur_o (clr_cur),
    .rd_ctrl_o   (rd_ctrl)
  );

  assign run_en = ctrl.run;
  assign irq_en = ctrl.irq_en;
  assign step   = run_en && (ctrl.src_core || div_pulse);

  tick_downcounter #(.CW(CW)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .step_i     (step),
    .clear_i    (clr_cur),
    .reload_i   (reload_val),
    .flag_clr_i (rd_ctrl),
    .count_o    (cnt_val),
    .flag_o     (cnt_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_irq <= 1'b0;
    end else begin
      tick_irq <= cnt_flag && irq_en;
    end
  end

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int unsigned CW  = 24,
  parameter int unsigned DW  = 32,
  parameter int unsigned DIV = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_en,
  input logic          bus_we,
  input logic [1:0]    bus_addr,
  input logic [DW-1:0] bus_rdata,
  input logic          tick_irq,
  input logic          run_en,
  input logic          irq_en,
  input logic          div_pulse,
  input logic [CW-1:0] cnt_val,
  input logic [CW-1:0] reload_val,
  input logic          cnt_flag
);

  logic wr_cur;
  logic rd_ctrl;
  logic rd_reload;

  assign wr_cur    = bus_en && bus_we && (bus_addr == 2'd2);
  assign rd_ctrl   = bus_en && !bus_we && (bus_addr == 2'd0);
  assign rd_reload = bus_en && !bus_we && (bus_addr == 2'd1);

  // R1
  a_r1_reload_upper_zero: assert property (@(posedge clk) disable iff (rst)
    rd_reload |=> ((bus_rdata >> CW) == '0));

  // R4
  a_r4_frozen_when_stopped: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !wr_cur) |=> $stable(cnt_val));

  // R5
  a_r5_clear_zero: assert property (@(posedge clk) disable iff (rst)
    wr_cur |=> (cnt_val == '0));

  // R6
  a_r6_flag_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_ctrl && (cnt_val != CW'(1))) |=> !cnt_flag);

  // R7
  a_r7_irq_from_flag: assert property (@(posedge clk) disable iff (rst)
    $rose(tick_irq) |-> ($past(cnt_flag) && $past(irq_en)));

  // R8
  a_r8_zero_reload_holds: assert property (@(posedge clk) disable iff (rst)
    (cnt_val == '0 && reload_val == '0 && !wr_cur) |=> (cnt_val == '0 && !$rose(cnt_flag)));

  generate
    if (DIV > 1) begin : g_div
      // R2
      a_r2_prescale_single: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> !div_pulse);
    end
  endgenerate

endmodule

bind tick_timer tick_timer_chk #(.CW(CW), .DW(DW), .DIV(DIV)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .bus_en     (bus_en),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .tick_irq   (tick_irq),
  .run_en     (run_en),
  .irq_en     (irq_en),
  .div_pulse  (div_pulse),
  .cnt_val    (cnt_val),
  .reload_val (reload_val),
  .cnt_flag   (cnt_flag)
);

// File: tb/tick_timer_tb_top.sv
module tick_timer_tb_top;

  logic        clk;
  logic        rst;
  logic        bus_en;
  logic        bus_we;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        tick_irq;

  int checks;
  int errors;
  int cyc;
  bit done;

  tick_timer dut_i (
    .clk       (clk),
    .rst       (rst),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tick_irq  (tick_irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int exp_period(input int r, input bit fast);
    return fast ? (r + 1) : 8 * (r + 1);
  endfunction

  function automatic logic [31:0] ctrl_word(input bit run, input bit ie, input bit fast);
    logic [31:0] w;
    w = '0;
    w[0] = run;
    w[1] = ie;
    w[2] = fast;
    return w;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_en = 1'b0;
  endtask

  // read control (clears flag) and let the interrupt line settle
  task automatic ack(output logic [31:0] d);
    bus_read(2'd0, d);
    @(negedge clk);
  endtask

  task automatic wait_rise(output int t);
    int n;
    n = 0;
    while (!tick_irq && n < 6000) begin
      @(negedge clk);
      n++;
    end
    check(tick_irq, "R7 tick_irq timeout", 0, 1);
    t = cyc;
  endtask

  task automatic configure(input int r, input bit fast, input bit ie);
    logic [31:0] d;
    bus_write(2'd0, 32'd0);
    bus_write(2'd1, 32'(r));
    bus_write(2'd2, 32'd0);
    ack(d);
    bus_write(2'd0, ctrl_word(1'b1, ie, fast));
  endtask

  task automatic period_check(input int r, input bit fast, input string tag);
    int t1, t2;
    logic [31:0] d;
    configure(r, fast, 1'b1);
    wait_rise(t1);
    ack(d);
    check(d[16], {tag, " flag bit set"}, d[16], 1);
    wait_rise(t2);
    check((t2 - t1) == exp_period(r, fast), tag, t2 - t1, exp_period(r, fast));
    ack(d);
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=finished", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    int t1, t2, t3, c;
    void'($urandom(32'h5eed_7123));
    checks = 0; errors = 0; cyc = 0; done = 0;
    rst = 1'b1; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R10 reset state
    check(tick_irq == 1'b0, "R10 reset irq", tick_irq, 0);
    bus_read(2'd0, d); check(d == 0, "R10 reset ctrl", d, 0);
    bus_read(2'd1, d); check(d == 0, "R10 reset reload", d, 0);
    bus_read(2'd2, d); check(d == 0, "R10 reset current", d, 0);
    bus_read(2'd3, d); check(d == 0, "R10 spare reads zero", d, 0);

    // R1 reload width
    bus_write(2'd1, 32'hFFFF_FFFF);
    bus_read(2'd1, d); check(d == 32'h00FF_FFFF, "R1 reload masked", d, 32'h00FF_FFFF);
    bus_write(2'd1, 32'hAB12_3456);
    bus_read(2'd1, d); check(d == 32'h0012_3456, "R1 reload low bits", d, 32'h0012_3456);

    // R10 control readback
    bus_write(2'd0, 32'h6);
    bus_read(2'd0, d); check(d == 32'h6, "R10 ctrl readback", d, 32'h6);

    // R4 stopped count holds, R5 clear
    bus_write(2'd1, 32'd100);
    bus_write(2'd0, ctrl_word(1'b1, 1'b0, 1'b1));
    repeat (10) @(negedge clk);
    bus_write(2'd0, 32'd0);
    bus_read(2'd2, d);
    check(d != 0, "R4 count moved while running", d, 1);
    repeat (20) @(negedge clk);
    bus_read(2'd2, d2);
    check(d2 == d, "R4 count frozen", d2, d);
    bus_write(2'd2, 32'h1234);
    bus_read(2'd2, d); check(d == 0, "R5 current cleared", d, 0);

    // R3 / R2 directed periods
    period_check(6, 1'b1, "R3 fast period r=6");
    period_check(10, 1'b0, "R2 slow period r=10");
    period_check(1, 1'b0, "R2 slow period r=1");

    // R9 reload rewrite takes effect at next reload
    configure(40, 1'b1, 1'b1);
    wait_rise(t1);
    ack(d);
    bus_write(2'd1, 32'd10);
    wait_rise(t2);
    check((t2 - t1) == 41, "R9 old reload finishes", t2 - t1, 41);
    ack(d);
    wait_rise(t3);
    check((t3 - t2) == 11, "R9 new reload used", t3 - t2, 11);
    ack(d);
    bus_read(2'd0, d);
    check(d[16] == 1'b0, "R6 flag cleared by read", d[16], 0);

    // R5 clear during run delays next tick
    configure(50, 1'b1, 1'b1);
    wait_rise(t1);
    ack(d);
    repeat (10) @(negedge clk);
    c = cyc;
    bus_write(2'd2, 32'd0);
    wait_rise(t2);
    check(t2 == c + 53, "R5 clear restarts period", t2 - c, 53);
    ack(d);

    // R7 interrupt gated by enable, flag still sticky
    configure(10, 1'b1, 1'b0);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (tick_irq) check(1'b0, "R7 irq while disabled", 1, 0);
    end
    checks++;
    bus_write(2'd0, ctrl_word(1'b1, 1'b1, 1'b1));
    @(negedge clk);
    check(tick_irq == 1'b1, "R7 irq after enable with pending flag", tick_irq, 1);
    bus_read(2'd0, d);
    check(d[16] == 1'b1, "R6 sticky flag", d[16], 1);

    // R8 zero reload
    configure(0, 1'b1, 1'b1);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (tick_irq) check(1'b0, "R8 irq with zero reload", 1, 0);
    end
    checks++;
    bus_read(2'd2, d); check(d == 0, "R8 count stays zero", d, 0);
    bus_read(2'd0, d); check(d[16] == 1'b0, "R8 no flag", d[16], 0);

    // R3 random periods
    for (int k = 0; k < 6; k++) begin
      int r;
      bit fast;
      r = $urandom_range(40, 6);
      fast = 1'($urandom_range(1, 0));
      period_check(r, fast, "R3 random period");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule